// File: doc/BRIEF.md
# Double-Buffered LCD Segment Pattern Store

This block holds the on/off pattern of every segment of a multiplexed LCD. It has two copies of the pattern. Software reads and writes the front copy through a simple word port. The segment scanner reads only the back copy. With the default parameters there are four common lines and two 32-bit words per common line, so each copy holds eight words. Word index `k` belongs to common line `k / 2` and is the half `k % 2` of that line.

To publish a new picture, software first writes the front words and then sets the update-request flag in the status register. At the next frame-start tick from the scanner, the block copies every front word into the back copy in a single cycle. In that same cycle it clears the request and sets a completion flag. From the moment the request is raised until the copy ends, the front words are locked and writes to them are dropped. The scanner therefore never sees a half-written picture, and software can work on the front copy at any point in a frame.

Top module: `seg_ram_dbuf`

## Requirements
- R1: After reset, all words of both copies read as zero and the status register reads zero.
- R2: When no request is pending, a write to RAM word address A updates front word A. The RAM read port returns the new value from the next cycle. Addresses 0 to 7 map to common line A/2, half A%2.
- R3: Writing the status register with bit 2 set raises the update request, which reads back as 1 in bit 2. A status write with bit 2 clear does not change the request. The request stays set until a copy takes place.
- R4: While the request is pending, RAM writes are ignored and leave every front word unchanged.
- R5: On a cycle where the request is pending and `frame_start_i` is high, all back words take the front words in that one clock edge. The request clears and the done flag (status bit 3) becomes 1.
- R6: The back copy, seen on the scan port, changes only through a copy. Front writes and frame ticks without a pending request leave it unchanged.
- R7: Writing the status register with bit 3 set clears the done flag, and a write with bit 3 clear leaves it unchanged. If a copy completes in the same cycle, the flag is set.
- R8: A request written in the same cycle as a frame tick is not served by that tick. The copy waits for the next tick. A RAM write made in that same cycle is still accepted.
- R9: The RAM read port always returns the front copy, including while a request is pending and after a copy. Status bits other than 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ram_we_i | input | 1 | RAM word write strobe |
| ram_waddr_i | input | 3 | RAM word write address |
| ram_wdata_i | input | 32 | RAM word write data |
| ram_raddr_i | input | 3 | RAM word read address |
| ram_rdata_o | output | 32 | Front word at the read address |
| stat_we_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 32 | Status write data: bit 2 sets the request, bit 3 clears the done flag |
| stat_o | output | 32 | Status: bit 2 request pending, bit 3 update done |
| frame_start_i | input | 1 | Frame-start tick from the scanner |
| scan_addr_i | input | 3 | Back word address from the scanner |
| scan_data_o | output | 32 | Back word at the scan address |

## Verification
The hardest cases to reach are those where several events land on the same clock edge. One is a request written in the same cycle as a frame tick, together with a RAM write. Another is a done-flag clear issued in the very cycle a copy completes. The stimulus drives each input in a chosen cycle, so it can put these events on one edge on purpose. After every cycle it compares all eight front words, all eight back words and the status register against a reference model. A write that should have been dropped, or an early copy, therefore shows up at the ports.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;
  localparam int STAT_REQ_BIT  = 2;
  localparam int STAT_DONE_BIT = 3;
endpackage

// File: rtl/seg_ram_front.sv
module seg_ram_front #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        lock_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);
  logic wr_en;
  assign wr_en = we_i & ~lock_i;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        words_o[i*DATA_W +: DATA_W] <= '0;
      else if (wr_en && (int'(waddr_i) == i))
        words_o[i*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < NUM_WORDS; j++)
      if (int'(raddr_i) == j) rdata_o = words_o[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/seg_ram_back.sv
module seg_ram_back #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        copy_i,
  input  logic [NUM_WORDS*DATA_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        words_o[i*DATA_W +: DATA_W] <= '0;
      else if (copy_i)
        words_o[i*DATA_W +: DATA_W] <= src_i[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < NUM_WORDS; j++)
      if (int'(raddr_i) == j) rdata_o = words_o[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/seg_upd_ctrl.sv
module seg_upd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_set_i,
  input  logic done_clr_i,
  input  logic frame_start_i,
  output logic req_o,
  output logic done_o,
  output logic copy_o
);
  // copy only on a tick seen after the request is already registered
  assign copy_o = req_o & frame_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      if (copy_o)         req_o <= 1'b0;
      else if (req_set_i) req_o <= 1'b1;
      if (copy_o)          done_o <= 1'b1;
      else if (done_clr_i) done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_ram_dbuf.sv
module seg_ram_dbuf #(
  parameter int NUM_COM       = 4,
  parameter int WORDS_PER_COM = 2,
  parameter int DATA_W        = 32,
  localparam int NUM_WORDS    = NUM_COM * WORDS_PER_COM,
  localparam int ADDR_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ram_we_i,
  input  logic [ADDR_W-1:0] ram_waddr_i,
  input  logic [DATA_W-1:0] ram_wdata_i,
  input  logic [ADDR_W-1:0] ram_raddr_i,
  output logic [DATA_W-1:0] ram_rdata_o,
  input  logic              stat_we_i,
  input  logic [DATA_W-1:0] stat_wdata_i,
  output logic [DATA_W-1:0] stat_o,
  input  logic              frame_start_i,
  input  logic [ADDR_W-1:0] scan_addr_i,
  output logic [DATA_W-1:0] scan_data_o
);
  import seg_ram_pkg::*;

  logic [NUM_WORDS*DATA_W-1:0] front_words;
  logic [NUM_WORDS*DATA_W-1:0] back_words;
  logic req_set, done_clr, req_q, done_q, copy;
  logic stat_unused;

  assign req_set     = stat_we_i & stat_wdata_i[STAT_REQ_BIT];
  assign done_clr    = stat_we_i & stat_wdata_i[STAT_DONE_BIT];
  assign stat_unused = ^{stat_wdata_i[DATA_W-1:STAT_DONE_BIT+1], stat_wdata_i[STAT_REQ_BIT-1:0]};

  always_comb begin
    stat_o                = '0;
    stat_o[STAT_REQ_BIT]  = req_q;
    stat_o[STAT_DONE_BIT] = done_q;
  end

  seg_upd_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_set_i     (req_set),
    .done_clr_i    (done_clr),
    .frame_start_i (frame_start_i),
    .req_o         (req_q),
    .done_o        (done_q),
    .copy_o        (copy)
  );

  seg_ram_front #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we_i),
    .lock_i  (req_q),
    .waddr_i (ram_waddr_i),
    .wdata_i (ram_wdata_i),
    .raddr_i (ram_raddr_i),
    .rdata_o (ram_rdata_o),
    .words_o (front_words)
  );

  seg_ram_back #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_back (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .copy_i  (copy),
    .src_i   (front_words),
    .raddr_i (scan_addr_i),
    .rdata_o (scan_data_o),
    .words_o (back_words)
  );
endmodule

// File: rtl/seg_ram_dbuf_chk.sv
module seg_ram_dbuf_chk #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        frame_start_i,
  input logic                        req_set,
  input logic                        done_clr,
  input logic                        req_q,
  input logic                        done_q,
  input logic [NUM_WORDS*DATA_W-1:0] front_words,
  input logic [NUM_WORDS*DATA_W-1:0] back_words
);
  // R3
  a_r3_req_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_set && !req_q |=> req_q);
  // R3
  a_r3_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !frame_start_i |=> req_q);
  // R4
  a_r4_front_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> $stable(front_words));
  // R5
  a_r5_copy_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && frame_start_i |=> (back_words == $past(front_words)) && !req_q && done_q);
  // R6
  a_r6_back_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_q && frame_start_i) |=> $stable(back_words));
  // R7
  a_r7_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_clr && !(req_q && frame_start_i) |=> !done_q);
endmodule

bind seg_ram_dbuf seg_ram_dbuf_chk #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .req_set       (req_set),
  .done_clr      (done_clr),
  .req_q         (req_q),
  .done_q        (done_q),
  .front_words   (front_words),
  .back_words    (back_words)
);

// File: tb/seg_ram_dbuf_bench.sv
module seg_ram_dbuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int TIMEOUT_CYC = 20000;

  typedef struct {
    int          kind;   // 0 front, 1 back, 2 status
    int          addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ram_we_i = 1'b0;
  logic [2:0] ram_waddr_i = '0;
  logic [31:0] ram_wdata_i = '0;
  logic [2:0] ram_raddr_i = '0;
  logic [31:0] ram_rdata_o;
  logic stat_we_i = 1'b0;
  logic [31:0] stat_wdata_i = '0;
  logic [31:0] stat_o;
  logic frame_start_i = 1'b0;
  logic [2:0] scan_addr_i = '0;
  logic [31:0] scan_data_o;

  item_t q[$];
  bit busy = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done_run = 0;

  logic [31:0] m_front [NW];
  logic [31:0] m_back  [NW];
  logic m_req = 0, m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_ram_dbuf u_seg_ram_dbuf (
    .clk_i(clk), .rst_ni(rst_ni),
    .ram_we_i(ram_we_i), .ram_waddr_i(ram_waddr_i), .ram_wdata_i(ram_wdata_i),
    .ram_raddr_i(ram_raddr_i), .ram_rdata_o(ram_rdata_o),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .stat_o(stat_o),
    .frame_start_i(frame_start_i), .scan_addr_i(scan_addr_i), .scan_data_o(scan_data_o)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      busy = 1;
      it = q.pop_front();
      if (it.kind == 0) ram_raddr_i = it.addr[2:0];
      else if (it.kind == 1) scan_addr_i = it.addr[2:0];
      #1;
      act = (it.kind == 0) ? ram_rdata_o : (it.kind == 1) ? scan_data_o : stat_o;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", it.tag, it.kind, it.addr, act, it.exp);
      end
      busy = 0;
    end
  end

  function automatic void push(int kind, int addr, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endfunction

  task automatic check_all(string tag);
    for (int i = 0; i < NW; i++) push(0, i, m_front[i], tag);
    for (int i = 0; i < NW; i++) push(1, i, m_back[i], tag);
    push(2, 0, {28'b0, m_done, m_req, 2'b00}, tag);
    wait (q.size() == 0 && !busy);
  endtask

  // one driven cycle, reference model updated from the requirements
  task automatic step(input bit we, input int wa, input logic [31:0] wd,
                      input bit swe, input logic [31:0] sd, input bit fs, input string tag);
    bit copy;
    @(negedge clk);
    ram_we_i = we; ram_waddr_i = wa[2:0]; ram_wdata_i = wd;
    stat_we_i = swe; stat_wdata_i = sd; frame_start_i = fs;
    copy = m_req && fs;
    if (copy) for (int i = 0; i < NW; i++) m_back[i] = m_front[i];
    if (we && !m_req) m_front[wa] = wd;
    if (copy) m_req = 0; else if (swe && sd[2]) m_req = 1;
    if (copy) m_done = 1; else if (swe && sd[3]) m_done = 0;
    @(negedge clk);
    ram_we_i = 0; stat_we_i = 0; frame_start_i = 0; stat_wdata_i = '0;
    check_all(tag);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin m_front[i] = '0; m_back[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check_all("R1 reset");

    for (int i = 0; i < NW; i++)
      step(1, i, 32'hA500_0000 + 32'(i * 32'h0101_0011), 0, '0, 0, "R2 R6 R9 front write");
    step(0, 0, '0, 0, '0, 1, "R8 R6 tick without request");
    step(1, 3, 32'hDEAD_BEEF, 1, 32'h0000_0004, 1, "R8 request on tick");
    step(1, 5, 32'h1234_5678, 0, '0, 0, "R4 R9 write while pending");
    step(0, 0, '0, 1, 32'hFFFF_FFF3, 0, "R3 R9 status write bit2 clear");
    step(1, 6, 32'h0BAD_F00D, 0, '0, 1, "R5 R4 copy on tick");
    step(1, 7, 32'hCAFE_0007, 0, '0, 0, "R6 R9 front after copy");
    step(0, 0, '0, 1, 32'h0000_0000, 0, "R7 done write zero");
    step(0, 0, '0, 1, 32'h0000_0008, 0, "R7 done clear");
    step(0, 0, '0, 1, 32'h0000_0004, 0, "R3 request again");
    step(0, 0, '0, 1, 32'h0000_0004, 0, "R3 request while pending");
    step(1, 0, 32'h5555_AAAA, 1, 32'h0000_0008, 1, "R7 R5 clear with copy");
    step(0, 0, '0, 0, '0, 1, "R6 R8 idle tick");
    done_run = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (TIMEOUT_CYC) @(posedge clk);
    if (!done_run) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule